// File: doc/BRIEF.md
# Nibble-Field Prioritized Interrupt Controller

This block collects interrupt requests from 28 peripheral sources and presents one request to a processor. The request is the highest active priority level together with the index of the source that owns it. Each source has its own 4-bit control field. The fields are packed eight to a 32-bit register, across four control registers on a simple word-addressed read/write bus. The low three bits of a field set the source's priority, and level 0 disables the source. The top bit of a field is a write strobe: the rest of the field is taken only when that bit is written as 1. Because of this, one register write can reprogram a single source and leave its seven neighbours unchanged.

Six of the sources are external pins. Each pin passes through a two-flop synchronizer and an edge detector, and a fifth register selects rising or falling edges per pin. A detected edge stays latched as pending until software writes the pin's field with the strobe bit set. That write is the acknowledge, and it acts whether the written priority is zero or not, so masking a pin also acknowledges it. The other 22 sources are level-sensitive. They are pending for as long as their input is high.

Top module: `ic_nibble_intc`

## Requirements
- R1: After reset every priority is 0, the polarity register is 0, `irq_level` and `irq_src` are 0, and reading any of the five registers returns 0 while all inputs are low.
- R2: Control register at word address a (0 to 3) holds source 8a+f in bits [31-4f : 28-4f] for field f = 0..7. Sources run from 0 to 27. Fields 4 to 7 of address 3 are unused: they read 0 and writes to them have no effect.
- R3: A write to a control register loads bits 2:0 of a field into that source's priority only when bit 3 of the field is 1. A field written with bit 3 = 0 leaves that source's priority unchanged.
- R4: A control register read returns each source's priority in bits 2:0 of its field and the source's current pending state in bit 3.
- R5: External pins are sources 0, 1, 2, 3, 25 and 26. An active edge on one of these pins latches it as pending, and it stays pending after the pin returns to its idle level.
- R6: The polarity register sits at word address 4. Bits 31, 30, 29 and 28 select the edge for sources 0 to 3, and bits 6 and 5 select it for sources 25 and 26. A 1 selects rising and a 0 selects falling. An edge of the other direction is ignored. All other bits read 0.
- R7: Writing an external source's field with bit 3 = 1 clears its latched edge, whether the written priority is 0 or not. An edge detected in the same cycle as that write remains latched.
- R8: Sources other than the six external pins are pending exactly while their input is high. Nothing is latched for them.
- R9: A source with priority 0 never drives the request, though its pending bit still reads back.
- R10: `irq_level` is the highest priority among pending sources with nonzero priority, and `irq_src` is that source's index. On a tie the lower index wins. When no source requests, both outputs are 0.
- R11: Outputs are registered. A change of a level input or a priority shows at the first rising edge after it takes effect. An external pin change applied between edges shows at the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address: 0-3 control, 4 polarity |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 28 | Source inputs; bits 0-3, 25, 26 are edge pins, the rest are levels |
| irq_level | output | 3 | Highest active priority, 0 when idle |
| irq_src | output | 5 | Index of the winning source |

## Verification
A lost or stuck edge latch is visible at the ports in two ways. It shows in bit 3 of the pin's field on the next read, and it raises `irq_level` at the first edge after the latch changes. A priority that was corrupted by a write with the strobe bit clear shows at once in the read-back of that field. A wrong tie-break or a wrong comparison in the selection logic shows on `irq_src` one clock after two sources are made equal. Synchronizer depth errors move the pin-to-request latency away from four edges, which the latency checks sample edge by edge.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int NREG     = 4;
    localparam int FPR      = 8;
    localparam int FW       = 4;
    localparam int NSRC     = 28;
    localparam int NEXT     = 6;
    localparam int PRIOW    = 3;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int POL_ADDR = NREG;
    localparam int IDXW     = $clog2(NSRC);
    localparam int SYNC_STAGES = 2;

    // source index of external pin e
    function automatic int ext_src(int e);
        return (e < 4) ? e : e + 21;
    endfunction

    // polarity bit of external pin e
    function automatic int ext_polbit(int e);
        return (e < 4) ? 31 - e : 10 - e;
    endfunction

    function automatic logic [NSRC-1:0] calc_ext_mask();
        logic [NSRC-1:0] m;
        m = '0;
        for (int e = 0; e < NEXT; e++) m[ext_src(e)] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] calc_pol_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int e = 0; e < NEXT; e++) m[ext_polbit(e)] = 1'b1;
        return m;
    endfunction

    localparam logic [NSRC-1:0] EXT_MASK = calc_ext_mask();
    localparam logic [DW-1:0]   POL_MASK = calc_pol_mask();

    typedef logic [PRIOW-1:0] prio_t;
endpackage

// File: rtl/ic_edge_detect.sv
module ic_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // sh_q[STAGES-1] is the newest synchronized value, sh_q[STAGES] the one before
    assign edge_o = rise_sel ? ( sh_q[STAGES-1] & ~sh_q[STAGES])
                             : (~sh_q[STAGES-1] &  sh_q[STAGES]);
endmodule

// File: rtl/ic_prio_pick.sv
module ic_prio_pick #(
    parameter int N    = 28,
    parameter int PW   = 3,
    parameter int IW   = 5
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][PW-1:0] prio,
    output logic [PW-1:0]        best_lvl,
    output logic [IW-1:0]        best_idx
);
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N; i++) begin
            if (req[i] && (prio[i] > best_lvl)) begin
                best_lvl = prio[i];
                best_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ic_nibble_intc.sv
module ic_nibble_intc
    import ic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NSRC-1:0]     src_in,
    output logic [PRIOW-1:0]    irq_level,
    output logic [IDXW-1:0]     irq_src
);
    typedef struct packed {
        logic [NSRC-1:0][PRIOW-1:0] prio;
        logic [NSRC-1:0]            latch;
        logic [DW-1:0]              pol;
        prio_t                      lvl;
        logic [IDXW-1:0]            src;
    } state_t;

    state_t st_d, st_q;

    logic [NEXT-1:0]  ext_edge;
    logic [NSRC-1:0]  edge_vec;
    logic [NSRC-1:0]  pending;
    prio_t            pick_lvl;
    logic [IDXW-1:0]  pick_idx;

    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        ic_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (src_in[ext_src(e)]),
            .rise_sel (st_q.pol[ext_polbit(e)]),
            .edge_o   (ext_edge[e])
        );
    end

    always_comb begin
        edge_vec = '0;
        for (int e = 0; e < NEXT; e++) edge_vec[ext_src(e)] = ext_edge[e];
    end

    assign pending = (st_q.latch & EXT_MASK) | (src_in & ~EXT_MASK);

    ic_prio_pick #(.N(NSRC), .PW(PRIOW), .IW(IDXW)) u_pick (
        .req      (pending),
        .prio     (st_q.prio),
        .best_lvl (pick_lvl),
        .best_idx (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NSRC; s++) begin
            logic hit;
            hit = bus_wr && (bus_addr == AW'(s / FPR))
                  && bus_wdata[DW-1-FW*(s % FPR)];
            if (hit) st_d.prio[s] = bus_wdata[DW-2-FW*(s % FPR) -: PRIOW];
            if (EXT_MASK[s]) st_d.latch[s] = edge_vec[s] | (st_q.latch[s] & ~hit);
            else             st_d.latch[s] = 1'b0;
        end
        if (bus_wr && (bus_addr == AW'(POL_ADDR))) st_d.pol = bus_wdata & POL_MASK;
        st_d.lvl = pick_lvl;
        st_d.src = pick_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (bus_addr == AW'(s / FPR))
                bus_rdata[DW-1-FW*(s % FPR) -: FW] = {pending[s], st_q.prio[s]};
        end
        if (bus_addr == AW'(POL_ADDR)) bus_rdata = st_q.pol;
    end

    assign irq_level = st_q.lvl;
    assign irq_src   = st_q.src;
endmodule

// File: rtl/ic_nibble_intc_chk.sv
module ic_nibble_intc_chk
    import ic_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [AW-1:0]              bus_addr,
    input logic [DW-1:0]              bus_wdata,
    input logic [DW-1:0]              bus_rdata,
    input logic [PRIOW-1:0]           irq_level,
    input logic [IDXW-1:0]            irq_src,
    input logic [NSRC-1:0]            latch_q,
    input logic [NSRC-1:0]            edge_vec,
    input logic [NSRC-1:0][PRIOW-1:0] prio_q
);
    assert_idle_src_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_src == '0));

    assert_src_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_src < IDXW'(NSRC));

    assert_pol_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(POL_ADDR)) |-> ((bus_rdata & ~POL_MASK) == '0));

    assert_hold_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr < AW'(NREG)) && ((bus_wdata & 32'h8888_8888) == '0))
        |=> $stable(prio_q));

    for (genvar e = 0; e < NEXT; e++) begin : g_ext_chk
        localparam int S = ext_src(e);
        assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == AW'(S / FPR)) && bus_wdata[DW-1-FW*(S % FPR)]
             && !edge_vec[S]) |=> !latch_q[S]);
        assert_edge_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
            edge_vec[S] |=> latch_q[S]);
    end
endmodule

bind ic_nibble_intc ic_nibble_intc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_level (irq_level),
    .irq_src   (irq_src),
    .latch_q   (st_q.latch),
    .edge_vec  (edge_vec),
    .prio_q    (st_q.prio)
);

// File: tb/ic_nibble_intc_bench.sv
`timescale 1ns/1ps
module ic_nibble_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] src_in = '0;
    logic [2:0]  irq_level;
    logic [4:0]  irq_src;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ic_nibble_intc u_ic_nibble_intc (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_level(irq_level), .irq_src(irq_src)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 level", 32'(irq_level), 0);
        chk("R1 src", 32'(irq_src), 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 0);
        end
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(3'd1, 32'hF9AB_CDE8);
        rd(3'd1, d); chk("R2 R4 field layout", d, 32'h7123_4560);
        wr(3'd1, 32'h0000_000F);
        rd(3'd1, d); chk("R3 single field", d, 32'h7123_4567);
        wr(3'd1, 32'h7777_7777);
        rd(3'd1, d); chk("R3 strobe clear ignored", d, 32'h7123_4567);
        wr(3'd1, 32'h8888_8888);
        rd(3'd1, d); chk("R3 all cleared", d, 32'h0);
        wr(3'd3, 32'h0000_FFFF);
        rd(3'd3, d); chk("R2 unused fields", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(3'd1, 32'h0B00_0000);            // source 9 priority 3
        @(negedge clk); src_in[9] = 1'b1;
        edges(1);
        chk("R11 level one edge", 32'(irq_level), 3);
        chk("R10 src 9", 32'(irq_src), 9);
        rd(3'd1, d); chk("R4 pending bit", d, 32'h0B00_0000);
        @(negedge clk); src_in[9] = 1'b0;
        edges(1);
        chk("R8 no latch level", 32'(irq_level), 0);
        rd(3'd1, d); chk("R8 pending drops", d, 32'h0300_0000);
        wr(3'd1, 32'h0000_B000);            // source 12 priority 3
        wr(3'd2, 32'h0000_B000);            // source 20 priority 3
        @(negedge clk); src_in[12] = 1'b1; src_in[20] = 1'b1;
        edges(1);
        chk("R10 tie lower index", 32'(irq_src), 12);
        wr(3'd2, 32'h0000_D000);            // source 20 priority 5
        chk("R11 old value at commit", 32'(irq_level), 3);
        edges(1);
        chk("R10 higher level", 32'(irq_level), 5);
        chk("R10 higher src", 32'(irq_src), 20);
        @(negedge clk); src_in[12] = 1'b0; src_in[20] = 1'b0; src_in[5] = 1'b1;
        edges(2);
        chk("R9 disabled no request", 32'(irq_level), 0);
        rd(3'd0, d); chk("R9 pending still visible", d, 32'h0000_0800);
        @(negedge clk); src_in[5] = 1'b0;
        wr(3'd1, 32'h8888_8888);
        wr(3'd2, 32'h8888_8888);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R6 polarity mask", d, 32'hF000_0060);
        wr(3'd4, 32'h8000_0040);            // src 0 and src 25 rising
        wr(3'd0, 32'hC000_0000);            // source 0 priority 4
        @(negedge clk); src_in[0] = 1'b1;
        edges(3);
        chk("R11 pin not yet at edge 3", 32'(irq_level), 0);
        edges(1);
        chk("R11 pin at edge 4", 32'(irq_level), 4);
        @(negedge clk); src_in[0] = 1'b0;
        edges(5);
        chk("R5 latched after pin drops", 32'(irq_level), 4);
        rd(3'd0, d); chk("R5 pending read", d, 32'hC000_0000);
        wr(3'd0, 32'hC000_0000);            // acknowledge, keep priority
        edges(1);
        chk("R7 ack clears", 32'(irq_level), 0);
        rd(3'd0, d); chk("R7 ack read", d, 32'h4000_0000);
        wr(3'd0, 32'h0A00_0000);            // source 1 priority 2, falling
        @(negedge clk); src_in[1] = 1'b1;
        edges(5);
        chk("R6 wrong edge ignored", 32'(irq_level), 0);
        @(negedge clk); src_in[1] = 1'b0;
        edges(5);
        chk("R6 falling level", 32'(irq_level), 2);
        chk("R6 falling src", 32'(irq_src), 1);
        wr(3'd0, 32'h0800_0000);            // mask source 1
        rd(3'd0, d); chk("R7 mask acks", d, 32'h4000_0000);
        wr(3'd0, 32'h0A00_0000);
        edges(2);
        chk("R7 stays cleared after unmask", 32'(irq_level), 0);
        wr(3'd3, 32'h0E00_0000);            // source 25 priority 6
        @(negedge clk); src_in[25] = 1'b1;
        edges(4);
        chk("R5 pin 25 level", 32'(irq_level), 6);
        chk("R5 pin 25 src", 32'(irq_src), 25);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_layout();
        t_level();
        t_edge();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule